// File: doc/BRIEF.md
# Adjustable Nanosecond Timer Counter

This block keeps a free-running time count that grows by a programmable step on every reference clock edge while counting is enabled. To trim the clock's rate in parts-per-billion steps, a second programmable step takes the place of the normal step once in every N clocks. N comes from a correction-period register, which holds N minus one. A correction step larger than the normal step makes the clock run fast. A smaller one makes it run slow.

The count can be set to fold back at a programmable period value. The part above the period is kept when it folds back. Each fold-back can emit a one-cycle event toward compare channels. Software reaches the block through a simple register bus. Writing a time value loads the running count. A restart command zeroes the count. The live count is not readable directly: a capture command first copies it into the time register, and software then reads that register. The register bus is a plain control path with no valid/ready handshake. A write takes effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `ntc_timer`

## Requirements
- R1: After reset, the control, time, period, correction-period and step registers all read 0, and `wrap_evt` is low.
- R2: While control bit 0 (run) is set, the count grows by the selected step on each clock. While it is clear, the count holds.
- R3: The step register holds the normal step in bits 6:0 and the correction step in bits 14:8. Other bits read 0. The correction step replaces the normal step on one clock in every (correction period + 1). A value of 0 applies it on every clock. Equal steps give no correction effect.
- R4: When either control bit 4 or bit 5 is set and the count plus the step reaches or passes the period register, the next count is that sum minus the period. Otherwise the count wraps modulo 2^32.
- R5: With control bit 7 set, every period fold-back produces a one-cycle pulse on `wrap_evt` in the cycle after the fold-back edge. With bit 7 clear, no pulse is produced.
- R6: Writing control bit 11 as 1 copies the count held before that edge into the time register, which reads at address 1. Bit 11 reads 1 for exactly one cycle after the write and then reads 0.
- R7: A write to address 1 loads the written value into the running count. This takes priority over restart and stepping.
- R8: Writing control bit 9 as 1 zeroes the count and the correction phase. Bit 9 always reads 0.
- R9: The address map is: 0 control, 1 time, 2 period, 3 correction period, 4 step. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wrap_evt | output | 1 | One-cycle pulse after a period fold-back |

## Verification
A write is consumed at one rising edge. The count advances at every later edge while run is set, so a run of n clocks is opened by one write and closed by a write n edges later. The bench then expects exactly n steps. A capture lands at the edge of its write, so the time register is sampled at the next falling edge. The capture flag is read at that falling edge and once more a cycle later. `wrap_evt` is registered one cycle behind the fold-back edge. The bench counts it at falling edges and compares the count before and after each run.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_TIME   = 3'd1,
    A_PERIOD = 3'd2,
    A_CPER   = 3'd3,
    A_STEP   = 3'd4
  } ntc_addr_e;

  localparam int B_RUN     = 0;
  localparam int B_PW_LO   = 4;
  localparam int B_PW_HI   = 5;
  localparam int B_EVT     = 7;
  localparam int B_RESTART = 9;
  localparam int B_CAPTURE = 11;

  localparam int NORM_LSB  = 0;
  localparam int CORR_LSB  = 8;
endpackage

// File: rtl/ntc_regs.sv
module ntc_regs #(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7,
  parameter int CPER_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  rdata,
  output logic              run_en,
  output logic              pwrap_en,
  output logic              evt_en,
  output logic              restart,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  period,
  output logic [CPER_W-1:0] corr_per,
  output logic [STEP_W-1:0] norm_step,
  output logic [STEP_W-1:0] corr_step
);
  import ntc_pkg::*;

  logic              run_q, evt_q, cap_flag;
  logic [1:0]        pw_q;
  logic [CNT_W-1:0]  time_q, period_q;
  logic [CPER_W-1:0] cper_q;
  logic [STEP_W-1:0] norm_q, corr_q;
  logic              wr_ctrl, cap_strobe;

  assign wr_ctrl    = wr && (addr == A_CTRL);
  assign cap_strobe = wr_ctrl && wdata[B_CAPTURE];
  assign restart    = wr_ctrl && wdata[B_RESTART];
  assign load       = wr && (addr == A_TIME);
  assign load_val   = wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      evt_q    <= 1'b0;
      pw_q     <= 2'b00;
      cap_flag <= 1'b0;
      time_q   <= '0;
      period_q <= '0;
      cper_q   <= '0;
      norm_q   <= '0;
      corr_q   <= '0;
    end else begin
      cap_flag <= cap_strobe;
      if (cap_strobe) time_q <= count;
      if (wr_ctrl) begin
        run_q <= wdata[B_RUN];
        evt_q <= wdata[B_EVT];
        pw_q  <= wdata[B_PW_HI:B_PW_LO];
      end
      if (wr && addr == A_PERIOD) period_q <= wdata;
      if (wr && addr == A_CPER)   cper_q   <= wdata[CPER_W-1:0];
      if (wr && addr == A_STEP) begin
        norm_q <= wdata[NORM_LSB +: STEP_W];
        corr_q <= wdata[CORR_LSB +: STEP_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[B_RUN]           = run_q;
        rdata[B_EVT]           = evt_q;
        rdata[B_PW_HI:B_PW_LO] = pw_q;
        rdata[B_CAPTURE]       = cap_flag;
      end
      A_TIME:   rdata = time_q;
      A_PERIOD: rdata = period_q;
      A_CPER:   rdata[CPER_W-1:0] = cper_q;
      A_STEP: begin
        rdata[NORM_LSB +: STEP_W] = norm_q;
        rdata[CORR_LSB +: STEP_W] = corr_q;
      end
      default: rdata = '0;
    endcase
  end

  assign run_en    = run_q;
  assign evt_en    = evt_q;
  assign pwrap_en  = |pw_q;
  assign period    = period_q;
  assign corr_per  = cper_q;
  assign norm_step = norm_q;
  assign corr_step = corr_q;

  // R6: capture flag lasts a single cycle unless re-armed
  assert_capture_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_flag && !cap_strobe |=> !cap_flag);
endmodule

// File: rtl/ntc_step_sel.sv
module ntc_step_sel #(
  parameter int STEP_W = 7,
  parameter int CPER_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              clr,
  input  logic [CPER_W-1:0] corr_per,
  input  logic [STEP_W-1:0] norm_step,
  input  logic [STEP_W-1:0] corr_step,
  output logic [STEP_W-1:0] step
);
  logic [CPER_W-1:0] phase_q;
  logic              fire;

  assign fire = (phase_q >= corr_per);
  assign step = fire ? corr_step : norm_step;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) phase_q <= '0;
    else if (run_en)   phase_q <= fire ? '0 : phase_q + 1'b1;
  end

  // R3: after a correction clock the phase starts over
  assert_phase_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && fire && !clr |=> phase_q == '0);
  // R2: phase frozen while stopped
  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en && !clr |=> $stable(phase_q));
endmodule

// File: rtl/ntc_accum.sv
module ntc_accum #(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              pwrap_en,
  input  logic              evt_en,
  input  logic              restart,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic [STEP_W-1:0] step,
  input  logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  count,
  output logic              wrap_evt
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] count_q;
  logic             evt_q;
  logic [EXT_W-1:0] sum, over;
  logic             hit;

  assign sum  = {1'b0, count_q} + {{(EXT_W-STEP_W){1'b0}}, step};
  assign over = sum - {1'b0, period};
  assign hit  = pwrap_en && (sum >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (load)         count_q <= load_val;
      else if (restart) count_q <= '0;
      else if (run_en) begin
        if (hit) begin
          count_q <= over[CNT_W-1:0];
          evt_q   <= evt_en;
        end else begin
          count_q <= sum[CNT_W-1:0];
        end
      end
    end
  end

  assign count    = count_q;
  assign wrap_evt = evt_q;

  // R2: count holds while stopped
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en && !load && !restart |=> $stable(count_q));
  // R7: a time write lands in the count
  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count_q == $past(load_val));
  // R8: restart zeroes the count
  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart && !load |=> count_q == '0);
  // R5: event only when enabled
  assert_evt_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> $past(evt_en) && $past(run_en));
endmodule

// File: rtl/ntc_timer.sv
module ntc_timer #(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7,
  parameter int CPER_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             wrap_evt
);
  logic              run_en, pwrap_en, evt_en, restart, load;
  logic [CNT_W-1:0]  load_val, period, count;
  logic [CPER_W-1:0] corr_per;
  logic [STEP_W-1:0] norm_step, corr_step, step;

  ntc_regs #(.CNT_W(CNT_W), .STEP_W(STEP_W), .CPER_W(CPER_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .count(count), .rdata(bus_rdata), .run_en(run_en), .pwrap_en(pwrap_en),
    .evt_en(evt_en), .restart(restart), .load(load), .load_val(load_val),
    .period(period), .corr_per(corr_per), .norm_step(norm_step),
    .corr_step(corr_step)
  );

  ntc_step_sel #(.STEP_W(STEP_W), .CPER_W(CPER_W)) u_step (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .clr(restart),
    .corr_per(corr_per), .norm_step(norm_step), .corr_step(corr_step),
    .step(step)
  );

  ntc_accum #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .pwrap_en(pwrap_en),
    .evt_en(evt_en), .restart(restart), .load(load), .load_val(load_val),
    .step(step), .period(period), .count(count), .wrap_evt(wrap_evt)
  );
endmodule

// File: tb/test_ntc_timer.sv
`timescale 1ns/1ps
module test_ntc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        wrap_evt;

  int n_checks = 0;
  int n_fails  = 0;
  int evt_cnt  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  ntc_timer i_ntc_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wrap_evt(wrap_evt)
  );

  always @(negedge clk) if (rst_n && wrap_evt) evt_cnt++;

  typedef struct packed {
    logic [6:0]  norm;
    logic [6:0]  corr;
    logic [15:0] cper;
    logic [31:0] period;
    logic [31:0] ctrl;
    logic [15:0] n;
    logic [31:0] expv;
    logic [7:0]  evts;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{7'd1,  7'd1,  16'd0, 32'd1000, 32'h31, 16'd10, 32'd10,  8'd0},
    '{7'd8,  7'd8,  16'd0, 32'd0,    32'h01, 16'd25, 32'd200, 8'd0},
    '{7'd10, 7'd11, 16'd4, 32'd0,    32'h01, 16'd20, 32'd204, 8'd0},
    '{7'd10, 7'd9,  16'd3, 32'd0,    32'h01, 16'd20, 32'd195, 8'd0},
    '{7'd10, 7'd12, 16'd0, 32'd0,    32'h01, 16'd7,  32'd84,  8'd0},
    '{7'd7,  7'd7,  16'd0, 32'd50,   32'hB1, 16'd10, 32'd20,  8'd1},
    '{7'd7,  7'd7,  16'd0, 32'd50,   32'h81, 16'd10, 32'd70,  8'd0},
    '{7'd5,  7'd5,  16'd0, 32'd50,   32'hB1, 16'd23, 32'd15,  8'd2}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // called at a falling edge; consumes exactly one rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic run(input logic [31:0] ctrl, input int n);
    wr(3'd0, ctrl | 32'h1);
    for (int k = 1; k < n; k++) @(negedge clk);
    wr(3'd0, 32'h0);
  endtask

  task automatic capture(output logic [31:0] v);
    wr(3'd0, 32'h800);
    rd(3'd1, v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 32'h0);
    rd(3'd2, v); check("R1 period", v, 32'h0);
    rd(3'd3, v); check("R1 corr period", v, 32'h0);
    rd(3'd4, v); check("R1 step", v, 32'h0);
    check("R1 wrap_evt", {31'd0, wrap_evt}, 32'h0);
    capture(v); check("R1 time", v, 32'h0);

    // R9 step field readback and masking
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); check("R9 R3 step mask", v, 32'h0000_7F7F);
    rd(3'd5, v); check("R9 unmapped", v, 32'h0);

    // table of runs: R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      wr(3'd4, {17'd0, VECS[i].corr, 1'b0, VECS[i].norm});
      wr(3'd3, {16'd0, VECS[i].cper});
      wr(3'd2, VECS[i].period);
      wr(3'd0, 32'h200);
      e0 = evt_cnt;
      run(VECS[i].ctrl, int'(VECS[i].n));
      @(negedge clk);
      capture(v);
      check($sformatf("R2 R3 R4 vector %0d count", i), v, VECS[i].expv);
      check($sformatf("R5 vector %0d events", i), evt_cnt - e0, {24'd0, VECS[i].evts});
    end

    // R6 capture flag pulse
    wr(3'd0, 32'h800);
    rd(3'd0, v); check("R6 flag set", v, 32'h800);
    @(negedge clk);
    rd(3'd0, v); check("R6 flag cleared", v, 32'h0);

    // R7 load, R2 hold
    wr(3'd4, 32'h0101);
    wr(3'd3, 32'h0);
    wr(3'd2, 32'h0);
    wr(3'd1, 32'd12345);
    repeat (4) @(negedge clk);
    capture(v); check("R7 R2 load then hold", v, 32'd12345);
    run(32'h0, 3);
    capture(v); check("R7 R2 run from loaded", v, 32'd12348);

    // R8 restart
    wr(3'd0, 32'h200);
    capture(v); check("R8 restart zero", v, 32'h0);
    rd(3'd0, v); check("R8 restart reads 0", v & 32'h200, 32'h0);

    // R4 modulo 2^32 without period wrap
    wr(3'd4, 32'h0303);
    wr(3'd1, 32'hFFFF_FFFE);
    run(32'h0, 1);
    capture(v); check("R4 2^32 wrap", v, 32'h1);

    // R4 R5 31-bit behaviour with period 2^31
    wr(3'd4, 32'h0101);
    wr(3'd2, 32'h8000_0000);
    wr(3'd1, 32'h7FFF_FFFE);
    e0 = evt_cnt;
    run(32'hB0, 3);
    @(negedge clk);
    capture(v); check("R4 period 2^31", v, 32'h1);
    check("R5 period 2^31 event", evt_cnt - e0, 32'd1);

    // R8 restart clears the correction phase
    wr(3'd2, 32'h0);
    wr(3'd4, 32'h0B0A);
    wr(3'd3, 32'd4);
    wr(3'd0, 32'h200);
    run(32'h0, 3);
    wr(3'd0, 32'h200);
    run(32'h0, 3);
    capture(v); check("R8 R3 phase cleared", v, 32'd30);

    finish_run();
  end
endmodule